// File: doc/BRIEF.md
# Pulse-Swallow Dual-Modulus Feedback Divider

This block is the feedback divider of a frequency synthesizer loop. It divides a fast input clock by N = B·P + A and emits one short pulse per N input cycles for a phase detector. The division is built from a dual-modulus prescaler that counts either P or P+1 input cycles. A swallow counter decides how many of those prescaler cycles use the longer modulus, and a main counter decides how many prescaler cycles make up one output period.

Software-facing logic outside the block presents a prescaler select, a swallow value and a main value, and strobes them into a pending set. The pending set becomes active only at the end of an output period, so that a period is never cut short. A hold control parks every counter at its load point and lets counting resume cleanly from there, which keeps the output aligned with the reference path when the hold is released. An error output reports a swallow value larger than the main value.

Top module: `swallow_divider`

## Requirements
- R1: With A ≤ B, consecutive output pulses are exactly B·P + A input clock cycles apart.
- R2: The prescaler select picks P: code 0 gives 8/9, code 1 gives 16/17, code 2 gives 32/33, code 3 gives 64/65.
- R3: Within each output period the first A prescaler cycles divide by P+1 and the remaining B−A by P; every A from 0 to 63 (including A = B) and every B from 3 to 8191 is accepted, so all ratios from P·P−P upward are reachable.
- R4: When the active A exceeds the active B, ab_err is 1 and the period becomes B·(P+1); otherwise ab_err is 0.
- R5: A cycle with load at 1 captures psel, a_val and b_val into a pending set without altering the period in progress.
- R6: Pending values become active, both counters reloading together, only at the terminal count of the main counter; the period after a load still uses the old ratio and the following one the new ratio.
- R7: div_pulse is high for exactly one clock cycle, in the cycle after the terminal count; the first pulse after reset or hold release comes N cycles after release.
- R8: While hold is 1, the counters sit at their load point, div_pulse stays 0, and pending values are made active; after hold falls the first pulse comes exactly N cycles later.
- R9: Synchronous reset clears div_pulse and ab_err and activates A = 0, B = 3, select 0, giving a 24-cycle period after release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast input clock to be divided |
| rst | input | 1 | Synchronous reset, active high |
| psel | input | 2 | Prescaler modulus select |
| a_val | input | 6 | Swallow count A |
| b_val | input | 13 | Main count B |
| load | input | 1 | Capture strobe for psel, a_val, b_val |
| hold | input | 1 | Hold counters at the load point |
| div_pulse | output | 1 | Divided output pulse, one cycle wide |
| ab_err | output | 1 | Active A is greater than active B |

## Verification
The divided pulse is registered, so it appears one cycle after the terminal count and the bench measures periods as the number of falling clock edges between two observed pulses. A load issued right after a pulse must leave the next interval at the old ratio and the interval after it at the new ratio, so every programming step checks two periods in turn. Release of reset or hold is driven at a falling edge and the first pulse is expected N falling edges later; ab_err is sampled in the pulse cycle, the first cycle in which the new values are active.

// File: rtl/swallow_divider.sv
module swallow_divider #(
  parameter int AW       = 6,
  parameter int BW       = 13,
  parameter int SW       = 2,
  parameter int PLOG_MIN = 3,
  parameter int RST_A    = 0,
  parameter int RST_B    = 3,
  parameter int RST_SEL  = 0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [SW-1:0] psel,
  input  logic [AW-1:0] a_val,
  input  logic [BW-1:0] b_val,
  input  logic          load,
  input  logic          hold,
  output logic          div_pulse,
  output logic          ab_err
);

  localparam int PCW = PLOG_MIN + (1 << SW);

  logic [SW-1:0]  pend_sel, act_sel;
  logic [AW-1:0]  pend_a, act_a, a_cnt;
  logic [BW-1:0]  pend_b, act_b, b_cnt;
  logic [PCW-1:0] pc;

  wire [PCW-1:0] base_p  = PCW'(1) << (PLOG_MIN + 32'(act_sel));
  wire           swallow = (a_cnt != '0);
  wire [PCW-1:0] last    = swallow ? base_p : base_p - PCW'(1);
  wire           pre_end = (pc == last);
  wire           term    = pre_end && (b_cnt == BW'(1));

  assign ab_err = {{(BW-AW){1'b0}}, act_a} > act_b;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_sel  <= SW'(RST_SEL);
      pend_a    <= AW'(RST_A);
      pend_b    <= BW'(RST_B);
      act_sel   <= SW'(RST_SEL);
      act_a     <= AW'(RST_A);
      act_b     <= BW'(RST_B);
      a_cnt     <= AW'(RST_A);
      b_cnt     <= BW'(RST_B);
      pc        <= '0;
      div_pulse <= 1'b0;
    end else begin
      if (load) begin
        pend_sel <= psel;
        pend_a   <= a_val;
        pend_b   <= b_val;
      end
      div_pulse <= term && !hold;
      if (hold || term) begin
        act_sel <= pend_sel;
        act_a   <= pend_a;
        act_b   <= pend_b;
        a_cnt   <= pend_a;
        b_cnt   <= pend_b;
        pc      <= '0;
      end else if (pre_end) begin
        pc    <= '0;
        b_cnt <= b_cnt - BW'(1);
        if (swallow) a_cnt <= a_cnt - AW'(1);
      end else begin
        pc <= pc + PCW'(1);
      end
    end
  end

  AST_PULSE_ONE_WIDE: assert property (@(posedge clk) disable iff (rst)
    div_pulse |=> !div_pulse); // R7

  AST_PULSE_AFTER_TERM: assert property (@(posedge clk) disable iff (rst)
    div_pulse |-> ($past(b_cnt) == BW'(1))); // R7

  AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (rst)
    hold |=> !div_pulse); // R8

  AST_HOLD_AT_LOAD: assert property (@(posedge clk) disable iff (rst)
    hold |=> (pc == '0 && b_cnt == act_b && a_cnt == act_a)); // R8

  AST_CFG_AT_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
    (!hold && !term) |=> ($stable(act_a) && $stable(act_b) && $stable(act_sel))); // R6

  AST_SWALLOW_BOUND: assert property (@(posedge clk) disable iff (rst)
    !ab_err |-> ({{(BW-AW){1'b0}}, a_cnt} <= b_cnt)); // R3

  AST_PRESCALE_RANGE: assert property (@(posedge clk) disable iff (rst)
    pc <= base_p); // R2

endmodule

// File: tb/test_swallow_divider.sv
module test_swallow_divider;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  psel = '0;
  logic [5:0]  a_val = '0;
  logic [12:0] b_val = 13'd3;
  logic        load = 1'b0;
  logic        hold = 1'b0;
  logic        div_pulse, ab_err;

  int vecs = 0;
  int errs = 0;
  int cur_n = 24;

  always #(CLK_PERIOD/2) clk = ~clk;

  swallow_divider i_swallow_divider (
    .clk(clk), .rst(rst), .psel(psel), .a_val(a_val), .b_val(b_val),
    .load(load), .hold(hold), .div_pulse(div_pulse), .ab_err(ab_err)
  );

  function automatic int ratio(int sel, int a, int b);
    int p = 8 << sel;
    return (a > b) ? b * (p + 1) : b * p + a;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    vecs++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic next_pulse(output int n);
    n = 0;
    do begin
      @(negedge clk);
      load = 1'b0;
      n++;
    end while (!div_pulse && n < 70000);
  endtask

  task automatic program_check(int sel, int a, int b, string tag);
    int n;
    int exp = ratio(sel, a, b);
    psel = 2'(sel); a_val = 6'(a); b_val = 13'(b); load = 1'b1;
    next_pulse(n);
    check(n == cur_n, "R5/R6 old ratio kept", n, cur_n);
    next_pulse(n);
    check(n == exp, tag, n, exp);
    check(ab_err == (a > b), "R4 error flag", int'(ab_err), int'(a > b));
    cur_n = exp;
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    errs++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    int n, hp;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check(div_pulse == 1'b0, "R9 pulse low in reset", int'(div_pulse), 0);
    check(ab_err == 1'b0, "R9 error low in reset", int'(ab_err), 0);
    rst = 1'b0;
    next_pulse(n);
    check(n == 24, "R9 default period", n, 24);
    next_pulse(n);
    check(n == 24, "R7 steady period", n, 24);

    program_check(3, 63, 63, "R3 A equals B, select 3");
    program_check(0, 0, 7, "R3 lowest contiguous ratio");
    program_check(0, 1, 7, "R3 contiguous plus one");
    program_check(1, 5, 20, "R2 select 1");
    program_check(2, 9, 11, "R2 select 2");
    program_check(0, 7, 1000, "R1 large B");
    program_check(2, 5, 3, "R4 A above B");
    program_check(0, 0, 3, "R1 minimum B");

    for (int i = 0; i < 12; i++) begin
      int s = $urandom_range(3, 0);
      int a = $urandom_range(63, 0);
      int b = $urandom_range(40, 3);
      program_check(s, a, b, "R1 random ratio");
    end

    // R8: hold mid-period with a load while held
    repeat (5) @(negedge clk);
    hold = 1'b1;
    psel = 2'd0; a_val = 6'd2; b_val = 13'd4; load = 1'b1;
    hp = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      load = 1'b0;
      if (div_pulse) hp++;
    end
    check(hp == 0, "R8 no pulse while held", hp, 0);
    hold = 1'b0;
    next_pulse(n);
    check(n == 34, "R8 resume from load point", n, 34);
    cur_n = 34;
    next_pulse(n);
    check(n == 34, "R7 period after hold", n, 34);

    program_check(1, 40, 10, "R4 error ratio before reset");
    check(ab_err == 1'b1, "R4 error held", int'(ab_err), 1);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check(div_pulse == 1'b0, "R9 pulse cleared", int'(div_pulse), 0);
    check(ab_err == 1'b0, "R9 error cleared", int'(ab_err), 0);
    rst = 1'b0;
    next_pulse(n);
    check(n == 24, "R9 defaults after reset", n, 24);

    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule